// File: doc/BRIEF.md
# Channel command stream decoder

This block turns a stream of 32-bit command words into register-write transactions for class engines that sit behind it. Words arrive one per valid/ready handshake. Each word is decoded either as a header or as a payload that belongs to the header before it. The choice depends on parser state the block keeps: the current class, the method offset, the count of payload words still owed, a pending sparse mask, and whether the offset advances.

Every header word has three fields. Bits 31:28 hold the mode, bits 27:16 hold a 12-bit method offset and bits 15:0 hold a 16-bit value field. The modes are: class select with an inline mask, incrementing burst, non-incrementing burst, sparse mask, and immediate data. Each write that comes out carries a 10-bit class, a 12-bit offset and 32 bits of data, and is held on an output valid/ready handshake until the receiver takes it.

Top module: `cmd_stream_decoder`

## Requirements
- R1: A header with mode 0 loads the class from bits 15:6, the offset from bits 27:16 and a 6-bit pending mask from bits 5:0. The header itself produces no write. The payload words that follow go to the newly loaded class.
- R2: A header with mode 1 loads a payload count from bits 15:0 and a base offset from bits 27:16. The next count words are each written to base plus their position in the burst.
- R3: A header with mode 2 loads a count and an offset in the same way as mode 1. Each of the next count words is written to that single offset.
- R4: A header with mode 3 loads a 16-bit mask from bits 15:0 and a base offset. Each following payload word goes to base plus the index of the lowest set bit that remains, and that bit is then cleared, so offsets rise from the lowest bit upward.
- R5: A header with mode 4 takes no payload. It issues one write at once to offset bits 27:16, with data equal to header bits 11:0 zero-extended, so bits 15:12 are dropped.
- R6: A word is decoded as a header only when the pending mask and the pending count are both zero. A header that carries a count of zero or a mask of zero consumes no payload.
- R7: A header with a mode value from 5 to 15 is dropped. It produces no write and leaves the parser state, including the class, unchanged. It sets an error flag that stays set until reset.
- R8: While a write is valid and not accepted, its class, offset and data stay stable and the input is stalled (in_ready low).
- R9: After reset no write is pending, in_ready is high, the error flag is low, and the class, offset, count and mask are all zero.
- R10: Every write carries the class that was current when the write was issued. Class 0x0F0, the video decoder class, is one such class.
- R11: Offsets are 12 bits wide. An incrementing burst or a mask index that passes 0xFFF wraps around to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A command word is offered |
| in_ready | output | 1 | The decoder accepts the offered word |
| in_word | input | 32 | Command word (header or payload) |
| wr_valid | output | 1 | A register write is offered |
| wr_ready | input | 1 | The receiver takes the write |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 12 | Method offset of the write |
| wr_data | output | 32 | Data of the write |
| err_flag | output | 1 | Sticky flag for an invalid header mode |

## Verification
The assertions check on every cycle the rules that depend on only one header or one handshake:
- a held write stays stable and the input stalls;
- headers of modes 0 to 3 never emit a write;
- an immediate header writes its own offset and 12-bit data on the next cycle;
- an invalid mode raises the error flag and the flag stays set;
- no write appears without an accepted word.

Some behaviour spans several words, and only the bench scenarios can show it. This covers how many payload words a header takes, the rising order of mask offsets, offset wrap-around, the class tag carried across later writes, and the fact that a dropped header leaves the class alone. The bench sweeps every inline mask, 259 sparse masks and burst lengths 0 to 6 at several base offsets, with random backpressure.

// File: rtl/cmdd_pkg.sv
`timescale 1ns/1ps
package cmdd_pkg;
    localparam int WORD_W    = 32;
    localparam int MODE_W    = 4;
    localparam int OFF_W     = 12;
    localparam int VAL_W     = 16;
    localparam int CLASS_W   = 10;
    localparam int IMM_W     = 12;
    localparam int INMASK_W  = 6;
    localparam int MODE_LSB  = WORD_W - MODE_W;
    localparam int OFF_LSB   = VAL_W;
    localparam int CLASS_LSB = INMASK_W;

    localparam logic [MODE_W-1:0] MODE_CLASS  = 4'd0;
    localparam logic [MODE_W-1:0] MODE_INCR   = 4'd1;
    localparam logic [MODE_W-1:0] MODE_FIXED  = 4'd2;
    localparam logic [MODE_W-1:0] MODE_SPARSE = 4'd3;
    localparam logic [MODE_W-1:0] MODE_IMM    = 4'd4;

    typedef struct packed {
        logic [CLASS_W-1:0] cls;
        logic [OFF_W-1:0]   off;
        logic [WORD_W-1:0]  data;
    } wr_t;

    typedef struct packed {
        logic [CLASS_W-1:0] cls;
        logic [OFF_W-1:0]   off;
        logic [VAL_W-1:0]   cnt;
        logic [VAL_W-1:0]   mask;
        logic               incr;
        logic               err;
        logic               wr_vld;
        wr_t                wr;
    } state_t;
endpackage

// File: rtl/cmdd_hdr_decode.sv
`timescale 1ns/1ps
module cmdd_hdr_decode
    import cmdd_pkg::*;
(
    input  logic [WORD_W-1:0]   word,
    output logic                is_class,
    output logic                is_incr,
    output logic                is_fixed,
    output logic                is_sparse,
    output logic                is_imm,
    output logic                is_bad,
    output logic [OFF_W-1:0]    off,
    output logic [VAL_W-1:0]    val,
    output logic [CLASS_W-1:0]  cls,
    output logic [VAL_W-1:0]    inline_mask,
    output logic [WORD_W-1:0]   imm_data
);
    logic [MODE_W-1:0] mode;

    always_comb begin
        mode        = word[WORD_W-1:MODE_LSB];
        off         = word[OFF_LSB +: OFF_W];
        val         = word[VAL_W-1:0];
        cls         = word[CLASS_LSB +: CLASS_W];
        inline_mask = {{(VAL_W-INMASK_W){1'b0}}, word[INMASK_W-1:0]};
        imm_data    = {{(WORD_W-IMM_W){1'b0}}, word[IMM_W-1:0]};
        is_class    = (mode == MODE_CLASS);
        is_incr     = (mode == MODE_INCR);
        is_fixed    = (mode == MODE_FIXED);
        is_sparse   = (mode == MODE_SPARSE);
        is_imm      = (mode == MODE_IMM);
        is_bad      = !(is_class || is_incr || is_fixed || is_sparse || is_imm);
    end
endmodule

// File: rtl/cmdd_lowbit_pick.sv
`timescale 1ns/1ps
module cmdd_lowbit_pick #(
    parameter int W = 16,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     rest
);
    logic [W:0]   seen;
    logic [W-1:0] first;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < W; g++) begin : g_chain
        assign first[g]  = vec[g] & ~seen[g];
        assign seen[g+1] = seen[g] | vec[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i]) idx = idx | IDX_W'(i);
        end
    end

    assign any  = seen[W];
    assign rest = vec & ~first;
endmodule

// File: rtl/cmd_stream_decoder.sv
`timescale 1ns/1ps
module cmd_stream_decoder
    import cmdd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_word,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [CLASS_W-1:0]  wr_class,
    output logic [OFF_W-1:0]    wr_offset,
    output logic [WORD_W-1:0]   wr_data,
    output logic                err_flag
);
    localparam int IDX_W = $clog2(VAL_W);

    state_t s_d, s_q;

    logic                h_class, h_incr, h_fixed, h_sparse, h_imm, h_bad;
    logic [OFF_W-1:0]    h_off;
    logic [VAL_W-1:0]    h_val;
    logic [CLASS_W-1:0]  h_cls;
    logic [VAL_W-1:0]    h_inmask;
    logic [WORD_W-1:0]   h_imm_data;

    logic                mask_any;
    logic [IDX_W-1:0]    mask_idx;
    logic [VAL_W-1:0]    mask_rest;

    logic                accept;
    logic                hdr_phase;

    cmdd_hdr_decode i_hdr (
        .word        (in_word),
        .is_class    (h_class),
        .is_incr     (h_incr),
        .is_fixed    (h_fixed),
        .is_sparse   (h_sparse),
        .is_imm      (h_imm),
        .is_bad      (h_bad),
        .off         (h_off),
        .val         (h_val),
        .cls         (h_cls),
        .inline_mask (h_inmask),
        .imm_data    (h_imm_data)
    );

    cmdd_lowbit_pick #(.W(VAL_W)) i_pick (
        .vec  (s_q.mask),
        .any  (mask_any),
        .idx  (mask_idx),
        .rest (mask_rest)
    );

    assign in_ready  = !s_q.wr_vld || wr_ready;
    assign accept    = in_valid && in_ready;
    assign hdr_phase = !mask_any && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (s_q.wr_vld && wr_ready) begin
            s_d.wr_vld = 1'b0;
        end
        if (accept) begin
            if (mask_any) begin
                // a pending mask goes first: lowest set bit picks the offset
                s_d.wr_vld  = 1'b1;
                s_d.wr.cls  = s_q.cls;
                s_d.wr.off  = s_q.off + OFF_W'(mask_idx);
                s_d.wr.data = in_word;
                s_d.mask    = mask_rest;
            end else if (s_q.cnt != '0) begin
                s_d.wr_vld  = 1'b1;
                s_d.wr.cls  = s_q.cls;
                s_d.wr.off  = s_q.off;
                s_d.wr.data = in_word;
                s_d.cnt     = s_q.cnt - VAL_W'(1);
                if (s_q.incr) begin
                    s_d.off = s_q.off + OFF_W'(1);
                end
            end else begin
                if (h_class) begin
                    s_d.cls  = h_cls;
                    s_d.off  = h_off;
                    s_d.mask = h_inmask;
                end
                if (h_incr || h_fixed) begin
                    s_d.cnt  = h_val;
                    s_d.off  = h_off;
                    s_d.incr = h_incr;
                end
                if (h_sparse) begin
                    s_d.mask = h_val;
                    s_d.off  = h_off;
                end
                if (h_imm) begin
                    s_d.off     = h_off;
                    s_d.wr_vld  = 1'b1;
                    s_d.wr.cls  = s_q.cls;
                    s_d.wr.off  = h_off;
                    s_d.wr.data = h_imm_data;
                end
                if (h_bad) begin
                    s_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_valid  = s_q.wr_vld;
    assign wr_class  = s_q.wr.cls;
    assign wr_offset = s_q.wr.off;
    assign wr_data   = s_q.wr.data;
    assign err_flag  = s_q.err;
endmodule

// File: rtl/cmdd_checker.sv
`timescale 1ns/1ps
module cmdd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [3:0]  in_mode,
    input logic [11:0] in_off,
    input logic [11:0] in_imm,
    input logic        hdr_phase,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [9:0]  wr_class,
    input logic [11:0] wr_offset,
    input logic [31:0] wr_data,
    input logic        err_flag
);
    logic take_hdr;
    assign take_hdr = in_valid && in_ready && hdr_phase;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_class) && $stable(wr_offset) && $stable(wr_data));

    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |-> !in_ready);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_bad_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_hdr && (in_mode > 4'd4) |=> err_flag && !wr_valid);

    assert_imm_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_hdr && (in_mode == 4'd4) |=> wr_valid && wr_offset == $past(in_off)
                                          && wr_data == {20'd0, $past(in_imm)});

    assert_quiet_header_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_hdr && (in_mode < 4'd4) |=> !wr_valid);

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(in_valid && in_ready));
endmodule

bind cmd_stream_decoder cmdd_checker i_cmdd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_word[31:28]),
    .in_off    (in_word[27:16]),
    .in_imm    (in_word[11:0]),
    .hdr_phase (hdr_phase),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_class  (wr_class),
    .wr_offset (wr_offset),
    .wr_data   (wr_data),
    .err_flag  (err_flag)
);

// File: tb/test_cmd_stream_decoder.sv
`timescale 1ns/1ps
module test_cmd_stream_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset;
    logic [31:0] wr_data;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;   // 0 random, 1 always ready, 2 never ready
    bit done = 0;
    logic [53:0] exp_q[$];
    logic [53:0] got_q[$];
    logic [31:0] dseed = 32'h0BAD_1000;
    logic [9:0]  cur_cls;

    always #4 clk = ~clk;

    cmd_stream_decoder i_cmd_stream_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_class(wr_class), .wr_offset(wr_offset), .wr_data(wr_data),
        .err_flag(err_flag)
    );

    always @(negedge clk) begin
        case (ready_mode)
            0:       wr_ready <= ($urandom % 3) != 0;
            1:       wr_ready <= 1'b1;
            default: wr_ready <= 1'b0;
        endcase
    end

    // record every write that will transfer at the coming rising edge
    always @(negedge clk) begin
        #2;
        if (rst_n && wr_valid && wr_ready) got_q.push_back({wr_class, wr_offset, wr_data});
    end

    function automatic logic [31:0] hdr(input logic [3:0] m, input logic [11:0] off, input logic [15:0] v);
        return {m, off, v};
    endfunction

    task automatic next_data(output logic [31:0] d);
        dseed = dseed + 32'h9E37_79B1;
        d = dseed;
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        forever begin
            #1;
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        #1;
        in_valid = 1'b0;
    endtask

    task automatic expw(input logic [9:0] c, input logic [11:0] o, input logic [31:0] d);
        exp_q.push_back({c, o, d});
    endtask

    task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        repeat (20) @(negedge clk);
        checks++;
        if (got_q.size() != exp_q.size()) begin
            errors++;
            $display("FAIL %s write count actual %0d expected %0d", tag, got_q.size(), exp_q.size());
        end else begin
            foreach (exp_q[i]) begin
                checks++;
                if (got_q[i] !== exp_q[i]) begin
                    errors++;
                    $display("FAIL %s write %0d actual %h expected %h", tag, i, got_q[i], exp_q[i]);
                end
            end
        end
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic marker();
        send(hdr(4'd4, 12'hABC, 16'h0055));
        expw(cur_cls, 12'hABC, 32'h055);
    endtask

    initial begin
        #(8ns * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [11:0] base;
        logic [9:0]  c;
        logic [15:0] m;
        logic [31:0] snap_data;
        logic [11:0] snap_off;
        logic [15:0] imm_vals[5];
        logic [15:0] extra_masks[3];

        repeat (3) @(negedge clk);
        #1;
        check1("R9 wr_valid in reset", {31'd0, wr_valid}, 32'd0);
        check1("R9 in_ready in reset", {31'd0, in_ready}, 32'd1);
        check1("R9 err_flag in reset", {31'd0, err_flag}, 32'd0);
        rst_n = 1'b1;
        cur_cls = 10'd0;

        // R9: reset class is zero
        send(hdr(4'd4, 12'h123, 16'h0ABC));
        expw(10'd0, 12'h123, 32'h0ABC);
        compare("R9");

        // R10: select video class with empty inline mask (R6: no payload consumed)
        send(hdr(4'd0, 12'h040, {10'h0F0, 6'd0}));
        cur_cls = 10'h0F0;
        send(hdr(4'd4, 12'h005, 16'h0007));
        expw(10'h0F0, 12'h005, 32'h7);
        compare("R10");

        // R1: every inline mask, class from bits 15:6
        for (int mi = 1; mi < 64; mi++) begin
            c = 10'((mi * 37) & 10'h3FF);
            base = 12'(mi * 50);
            send(hdr(4'd0, base, {c, 6'(mi)}));
            cur_cls = c;
            for (int b = 0; b < 6; b++) begin
                if (((mi >> b) & 1) != 0) begin
                    next_data(d);
                    send(d);
                    expw(c, base + 12'(b), d);
                end
            end
            marker();
            compare("R1");
        end

        send(hdr(4'd0, 12'h000, {10'h0F0, 6'd0}));
        cur_cls = 10'h0F0;

        // R2 / R11 incrementing, R3 non-incrementing, counts 0..6
        for (int mode = 1; mode <= 2; mode++) begin
            for (int bi = 0; bi < 3; bi++) begin
                base = (bi == 0) ? 12'h000 : (bi == 1) ? 12'h7F0 : 12'hFFD;
                for (int n = 0; n <= 6; n++) begin
                    send(hdr(4'(mode), base, 16'(n)));
                    for (int i = 0; i < n; i++) begin
                        next_data(d);
                        send(d);
                        expw(10'h0F0, (mode == 1) ? base + 12'(i) : base, d);
                    end
                    marker();
                    if (n == 0) compare("R6");
                    else if (mode == 2) compare("R3");
                    else if (bi == 2) compare("R11");
                    else compare("R2");
                end
            end
        end

        // R4 sparse masks, ascending bit order
        extra_masks[0] = 16'h8001;
        extra_masks[1] = 16'hFFFF;
        extra_masks[2] = 16'h4000;
        for (int mi = 0; mi < 259; mi++) begin
            m = (mi < 256) ? 16'(mi) : extra_masks[mi - 256];
            base = 12'((mi * 13) & 12'hFFF);
            if (mi == 258) base = 12'hFFA;
            send(hdr(4'd3, base, m));
            for (int b = 0; b < 16; b++) begin
                if (m[b]) begin
                    next_data(d);
                    send(d);
                    expw(10'h0F0, base + 12'(b), d);
                end
            end
            marker();
            if (m == 16'd0) compare("R6");
            else if (mi == 258) compare("R11");
            else compare("R4");
        end

        // R5 immediate data keeps only bits 11:0
        imm_vals[0] = 16'h0000;
        imm_vals[1] = 16'h0FFF;
        imm_vals[2] = 16'hF123;
        imm_vals[3] = 16'h8ABC;
        imm_vals[4] = 16'h5001;
        for (int k = 0; k < 5; k++) begin
            base = 12'(k * 811);
            send(hdr(4'd4, base, imm_vals[k]));
            expw(10'h0F0, base, {20'd0, imm_vals[k][11:0]});
        end
        compare("R5");

        // R7 invalid modes dropped, class kept, flag sticky
        send(hdr(4'd0, 12'h000, {10'h155, 6'd0}));
        cur_cls = 10'h155;
        repeat (2) @(negedge clk);
        #1;
        check1("R7 err before bad header", {31'd0, err_flag}, 32'd0);
        for (int mode = 5; mode < 16; mode++) begin
            send(hdr(4'(mode), 12'h111, 16'hFFFF));
            @(negedge clk);
            #1;
            check1("R7 err after bad header", {31'd0, err_flag}, 32'd1);
            send(hdr(4'd4, 12'h222, 16'h0033));
            expw(10'h155, 12'h222, 32'h33);
        end
        compare("R7");
        check1("R7 err stays set", {31'd0, err_flag}, 32'd1);

        // R8 backpressure: output held, input stalled
        ready_mode = 1;
        repeat (3) @(negedge clk);
        ready_mode = 2;
        repeat (2) @(negedge clk);
        send(hdr(4'd4, 12'h321, 16'h0777));
        @(negedge clk);
        #1;
        check1("R8 write pending", {31'd0, wr_valid}, 32'd1);
        snap_data = wr_data;
        snap_off  = wr_offset;
        repeat (5) begin
            @(negedge clk);
            #1;
            check1("R8 valid held", {31'd0, wr_valid}, 32'd1);
            check1("R8 offset held", {20'd0, wr_offset}, {20'd0, snap_off});
            check1("R8 data held", wr_data, snap_data);
            check1("R8 input stalled", {31'd0, in_ready}, 32'd0);
        end
        expw(10'h155, 12'h321, 32'h777);
        ready_mode = 1;
        compare("R8");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule